// File: doc/BRIEF.md
# Serial EEPROM Address Front End

This block is the receive side of the addressing phase of a two-wire serial EEPROM slave whose array holds 4096 bytes. The array is seen as 128 pages of 32 bytes. The block samples the clock and data wires into a fast system clock and recognises bus Start and Stop conditions. It shifts in the first byte after a Start and compares it with a fixed device type code and three strap inputs. It then acknowledges the byte or lets it pass unacknowledged.

For a write selection it takes the next two bytes and assembles a 12-bit byte pointer from them, then strobes the pointer to a downstream memory controller. A read selection carries no word address here. The block flags it as a current-address read, and the controller keeps its own pointer. In the pointer, bits 4..0 select the byte within a page and bits 11..5 select the page.

The memory array, the page buffer, write-cycle timing and the read data path belong to the downstream controller.

Top module: `ee_addr_front`

## Requirements
- R1: A Start is the data wire falling while the clock wire is high, and a Stop is the data wire rising while the clock wire is high. After a Stop, no byte is acknowledged until a new Start arrives.
- R2: The first byte after a Start is selected only when its bits 7..4 equal binary 1010. Any other value there gives no acknowledge.
- R3: The first byte is selected only when its bit 3 equals `strap[2]`, its bit 2 equals `strap[1]` and its bit 1 equals `strap[0]`. A strap that differs gives no acknowledge.
- R4: After an unselected first byte, no later byte is acknowledged and neither `addrValid` nor `curRead` pulses until the next Start.
- R5: Bytes are taken MSB first on rising clock edges. `sdaDriveLow` is asserted only while the clock wire is low after the eighth bit, stays asserted through the ninth clock pulse, and drops after the ninth clock falls. It is never asserted during the eight data bits.
- R6: When the first byte selects the device with bit 0 = 0 (write), the next two bytes are acknowledged. `wordAddr` becomes {first word byte bits 3..0, second word byte}, bits 7..4 of the first word byte are ignored, and `addrValid` pulses for exactly one cycle. `rdNotWr` reads 0.
- R7: When the first byte selects the device with bit 0 = 1 (read), `curRead` pulses for exactly one cycle, `rdNotWr` reads 1, and `wordAddr` keeps its previous value.
- R8: A Start that arrives in the middle of a byte discards the partial byte and restarts device byte reception.
- R9: After the address phase ends (after the second word byte of a write, or after the device byte of a read), no further byte is acknowledged until the next Start.
- R10: After reset, `sdaDriveLow`, `addrValid`, `curRead` and `rdNotWr` read 0 and `wordAddr` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock wire, asynchronous |
| sdaIn | input | 1 | Bus data wire as seen on the bus, asynchronous |
| strap | input | 3 | Board strap bits compared with device byte bits 3..1 |
| sdaDriveLow | output | 1 | 1 pulls the data wire low (acknowledge) |
| rdNotWr | output | 1 | Direction of the last selection, 1 = read |
| wordAddr | output | 12 | Captured byte pointer |
| addrValid | output | 1 | One-cycle strobe: new `wordAddr` captured |
| curRead | output | 1 | One-cycle strobe: current-address read requested |

## Verification
Directed transfers cover several cases: a write to the top and the bottom of the array with junk in the ignored nibble, a wrong type code, a wrong strap, a read after a write, a Stop between the device byte and further bytes, and a Start cut into a half-sent byte. Each one separates selection from rejection, or capture from retention of the pointer. Seeded random transfers then mix matching and non-matching device bytes, directions, strap settings and pointer values. They show that the acknowledge decision follows both the type code and the straps, and that the pointer is assembled from the correct nibble and byte. Every transfer also probes one extra byte after the address phase, to show that the block stays silent there.

// File: rtl/ee_front_pkg.sv
package ee_front_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WHI,
    ST_WLO,
    ST_DONE,
    ST_SKIP
  } phase_t;

  typedef struct packed {
    logic clrBits;
    logic loadHi;
    logic loadLo;
    logic loadDir;
    logic dirRead;
  } ctl_t;

endpackage

// File: rtl/ee_front_dp.sv
module ee_front_dp
  import ee_front_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  ctl_t             ctl,
  output logic             sclFall,
  output logic             startSeen,
  output logic             stopSeen,
  output logic             byteFull,
  output logic [7:0]       rxByte,
  output logic [PTR_W-1:0] wordAddr,
  output logic             rdNotWr
);
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);
  localparam int HI_W      = PTR_W - BYTE_BITS;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev, sclRise;
  logic [CNT_W-1:0] bitCnt;
  logic [HI_W-1:0] hiNib;

  // two-wire inputs cross into clk through a flop chain; idle bus level is 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclPipe[SYNC_STAGES-1];
  assign sdaS      = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign byteFull  = (bitCnt == FULL);

  // bit shifter, MSB first on rising clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (startSeen || ctl.clrBits) begin
      bitCnt <= '0;
    end else if (sclRise && !byteFull) begin
      rxByte <= {rxByte[6:0], sdaS};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // pointer and direction registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib    <= '0;
      wordAddr <= '0;
      rdNotWr  <= 1'b0;
    end else begin
      if (ctl.loadHi)  hiNib    <= rxByte[HI_W-1:0];
      if (ctl.loadLo)  wordAddr <= {hiNib, rxByte};
      if (ctl.loadDir) rdNotWr  <= ctl.dirRead;
    end
  end
endmodule

// File: rtl/ee_front_ctl.sv
module ee_front_ctl
  import ee_front_pkg::*;
#(
  parameter int                  STRAP_W   = 3,
  parameter logic [6-STRAP_W:0]  TYPE_CODE = 'hA
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclFall,
  input  logic               startSeen,
  input  logic               stopSeen,
  input  logic               byteFull,
  input  logic [7:0]         rxByte,
  input  logic [STRAP_W-1:0] strap,
  output ctl_t               ctl,
  output logic               sdaDriveLow,
  output logic               addrValid,
  output logic               curRead
);
  phase_t state, afterAck, nxt;
  logic inAck, ackNow, devMatch, addrPhase, evalNow, endAck;

  assign devMatch  = (rxByte[7:STRAP_W+1] == TYPE_CODE) && (rxByte[STRAP_W:1] == strap);
  assign addrPhase = (state == ST_DEV) || (state == ST_WHI) || (state == ST_WLO);
  assign evalNow   = sclFall & ~inAck & byteFull & addrPhase & ~startSeen & ~stopSeen;
  assign endAck    = sclFall & inAck & ~startSeen & ~stopSeen;

  always_comb begin
    ackNow = 1'b0;
    nxt    = ST_SKIP;
    case (state)
      ST_DEV: if (devMatch) begin
        ackNow = 1'b1;
        nxt    = rxByte[0] ? ST_DONE : ST_WHI;
      end
      ST_WHI: begin ackNow = 1'b1; nxt = ST_WLO;  end
      ST_WLO: begin ackNow = 1'b1; nxt = ST_DONE; end
      default: ;
    endcase
  end

  always_comb begin
    ctl.clrBits = endAck;
    ctl.loadDir = evalNow & (state == ST_DEV) & devMatch;
    ctl.dirRead = rxByte[0];
    ctl.loadHi  = evalNow & (state == ST_WHI);
    ctl.loadLo  = evalNow & (state == ST_WLO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      afterAck    <= ST_IDLE;
      inAck       <= 1'b0;
      sdaDriveLow <= 1'b0;
      addrValid   <= 1'b0;
      curRead     <= 1'b0;
    end else begin
      addrValid <= ctl.loadLo;
      curRead   <= ctl.loadDir & rxByte[0];
      if (startSeen) begin
        state       <= ST_DEV;
        inAck       <= 1'b0;
        sdaDriveLow <= 1'b0;
      end else if (stopSeen) begin
        state       <= ST_IDLE;
        inAck       <= 1'b0;
        sdaDriveLow <= 1'b0;
      end else if (evalNow) begin
        inAck       <= 1'b1;
        sdaDriveLow <= ackNow;
        afterAck    <= nxt;
      end else if (endAck) begin
        inAck       <= 1'b0;
        sdaDriveLow <= 1'b0;
        state       <= afterAck;
      end
    end
  end
endmodule

// File: rtl/ee_addr_front.sv
module ee_addr_front
  import ee_front_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [2:0]       strap,
  output logic             sdaDriveLow,
  output logic             rdNotWr,
  output logic [PTR_W-1:0] wordAddr,
  output logic             addrValid,
  output logic             curRead
);
  ctl_t ctl;
  logic sclFall, startSeen, stopSeen, byteFull;
  logic [7:0] rxByte;

  ee_front_dp #(.SYNC_STAGES(SYNC_STAGES), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .byteFull(byteFull), .rxByte(rxByte), .wordAddr(wordAddr), .rdNotWr(rdNotWr)
  );

  ee_front_ctl #(.STRAP_W(3), .TYPE_CODE(4'hA)) u_ctl (
    .clk(clk), .rstN(rstN), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .byteFull(byteFull), .rxByte(rxByte), .strap(strap),
    .ctl(ctl), .sdaDriveLow(sdaDriveLow), .addrValid(addrValid), .curRead(curRead)
  );
endmodule

// File: rtl/ee_front_chk.sv
module ee_front_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaDriveLow,
  input logic addrValid,
  input logic curRead,
  input logic rdNotWr
);
  // R5: acknowledge drive only ever begins while the clock wire is low
  p_ack_starts_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);

  // R6: pointer strobe lasts one cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid);

  // R7: current-read strobe lasts one cycle
  p_curread_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    curRead |=> !curRead);

  // R7: a current-read strobe always reports read direction
  p_curread_dir_r7: assert property (@(posedge clk) disable iff (!rstN)
    curRead |-> rdNotWr);

  // R6: a pointer strobe always reports write direction
  p_valid_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> !rdNotWr);
endmodule

bind ee_addr_front ee_front_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .addrValid(addrValid), .curRead(curRead), .rdNotWr(rdNotWr)
);

// File: tb/ee_addr_front_bench.sv
module ee_addr_front_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [2:0] strap = 3'd0;
  logic sdaDriveLow, rdNotWr, addrValid, curRead;
  logic [11:0] wordAddr;
  wire sdaBus = mSda & ~sdaDriveLow;

  int total = 0;
  int bad = 0;
  int avCnt = 0;
  int crCnt = 0;
  int bitDriveErr = 0;
  logic [11:0] avAddr = '0;

  always #10 clk = ~clk;

  ee_addr_front u_ee_addr_front (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .strap(strap),
    .sdaDriveLow(sdaDriveLow), .rdNotWr(rdNotWr), .wordAddr(wordAddr),
    .addrValid(addrValid), .curRead(curRead)
  );

  always @(posedge clk) begin
    if (addrValid) begin avCnt <= avCnt + 1; avAddr <= wordAddr; end
    if (curRead) crCnt <= crCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    mSda = b; tick(4);
    mScl = 1'b1; tick(4);
    if (sdaDriveLow) bitDriveErr++;
    tick(4);
    mScl = 1'b0; tick(4);
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) sendBit(v[i]);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked, output bit released);
    sendBits(v, 8);
    mSda = 1'b1; tick(4);
    mScl = 1'b1; tick(4);
    acked = (sdaBus == 1'b0);
    tick(4);
    mScl = 1'b0; tick(6);
    released = !sdaDriveLow;
  endtask

  task automatic busStart();
    if (!mScl) begin mSda = 1'b1; tick(4); mScl = 1'b1; tick(6); end
    mSda = 1'b0; tick(6);
    mScl = 1'b0; tick(4);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(4);
    mScl = 1'b1; tick(6);
    mSda = 1'b1; tick(8);
  endtask

  function automatic bit expSel(input logic [7:0] dev, input logic [2:0] s);
    return (dev[7:4] == 4'hA) && (dev[3:1] == s);
  endfunction

  function automatic logic [11:0] expPtr(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[3:0], lo};
  endfunction

  // write selection plus two word bytes plus one extra byte
  task automatic doWrite(input logic [7:0] dev, input logic [7:0] b1, input logic [7:0] b2);
    bit a0, a1, a2, a3, r0, r1, r2, r3, sel;
    int avBefore;
    logic [11:0] ptrBefore;
    avBefore = avCnt; ptrBefore = wordAddr;
    sel = expSel(dev, strap);
    busStart();
    sendByte(dev, a0, r0);
    sendByte(b1, a1, r1);
    sendByte(b2, a2, r2);
    sendByte(8'h5A, a3, r3);
    busStop();
    chk(a0 == sel, "R2/R3", "device byte ack", a0, sel);
    chk(r0 && r1 && r2 && r3, "R5", "release after ninth clock", 0, 1);
    if (sel) begin
      chk(a1 && a2, "R6", "word bytes acked", {a1, a2}, 3);
      chk(avCnt == avBefore + 1, "R6", "addrValid pulses", avCnt - avBefore, 1);
      chk(avAddr == expPtr(b1, b2), "R6", "pointer value", avAddr, expPtr(b1, b2));
      chk(wordAddr == expPtr(b1, b2), "R6", "wordAddr held", wordAddr, expPtr(b1, b2));
      chk(rdNotWr == 1'b0, "R6", "direction write", rdNotWr, 0);
      chk(!a3, "R9", "byte after address phase", a3, 0);
    end else begin
      chk(!a1 && !a2 && !a3, "R4", "bytes after reject", {a1, a2, a3}, 0);
      chk(avCnt == avBefore, "R4", "no addrValid", avCnt - avBefore, 0);
      chk(wordAddr == ptrBefore, "R4", "pointer unchanged", wordAddr, ptrBefore);
    end
  endtask

  task automatic doRead(input logic [7:0] dev);
    bit a0, a1, r0, r1, sel;
    int crBefore;
    logic [11:0] ptrBefore;
    crBefore = crCnt; ptrBefore = wordAddr;
    sel = expSel(dev, strap);
    busStart();
    sendByte(dev, a0, r0);
    sendByte(8'hFF, a1, r1);
    busStop();
    chk(a0 == sel, "R2/R3", "read device ack", a0, sel);
    chk(!a1, "R9", "no ack after read select", a1, 0);
    chk(wordAddr == ptrBefore, "R7", "pointer kept on read", wordAddr, ptrBefore);
    if (sel) begin
      chk(crCnt == crBefore + 1, "R7", "curRead pulses", crCnt - crBefore, 1);
      chk(rdNotWr == 1'b1, "R7", "direction read", rdNotWr, 1);
    end else begin
      chk(crCnt == crBefore, "R4", "no curRead on reject", crCnt - crBefore, 0);
    end
  endtask

  initial begin
    bit a0, a1, r0, r1;
    int avBefore;
    void'($urandom(32'd20240611));
    tick(5);
    chk(!sdaDriveLow && !addrValid && !curRead && !rdNotWr && wordAddr == 0,
        "R10", "reset state", wordAddr, 0);
    rstN = 1'b1;
    tick(5);

    // R6: top of array, junk nibble ignored
    strap = 3'b000;
    doWrite(8'hA0, 8'hFF, 8'hFF);
    // R6: bottom of array
    doWrite(8'hA0, 8'h30, 8'h00);
    // R2: wrong type code
    doWrite(8'hB0, 8'h01, 8'h23);
    // R3: straps 101, device byte with matching then mismatching strap field
    strap = 3'b101;
    doWrite(8'hAA, 8'h9C, 8'h3E);
    doWrite(8'hA8, 8'h01, 8'h02);
    // R7: read after write keeps pointer
    doRead(8'hAB);
    doRead(8'hA3);

    // R1: Stop right after device byte, later bytes unheard
    avBefore = avCnt;
    busStart();
    sendByte(8'hAA, a0, r0);
    busStop();
    sendByte(8'h01, a1, r1);
    chk(a0, "R1", "device ack before stop", a0, 1);
    chk(!a1, "R1", "byte after stop", a1, 0);
    sendByte(8'h02, a1, r1);
    chk(!a1 && avCnt == avBefore, "R1", "no capture after stop", avCnt - avBefore, 0);

    // R8: Start cutting a half-sent byte
    busStart();
    sendBits(8'hAA, 4);
    doWrite(8'hAA, 8'h07, 8'h65);
    chk(avAddr == 12'h765, "R8", "capture after restart", avAddr, 12'h765);

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [7:0] dev, b1, b2;
      strap = 3'($urandom);
      b1 = 8'($urandom);
      b2 = 8'($urandom);
      dev = ($urandom % 2) ? {4'hA, strap, 1'b0} : 8'($urandom);
      if ($urandom % 3 == 0) doRead({dev[7:1], 1'b1});
      else doWrite({dev[7:1], 1'b0}, b1, b2);
    end

    chk(bitDriveErr == 0, "R5", "no drive during data bits", bitDriveErr, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule